// File: doc/BRIEF.md
# Framer Interrupt Aggregation Controller

This block collects interrupt events from the eight functional groups of a single-channel framer and drives one active-low interrupt line. Each group has `NSRC` source events. Each source event sets a sticky status bit. A per-source enable and a per-group enable decide whether that bit can reach the output. A framer-level master enable gates the whole tree.

A host reads and services the block over a synchronous 8-bit register bus. A control register selects how sticky bits are cleared:

- by the read that returns them (read-clear), or
- by writing 1 to them (write-one-clear).

The control register can also make the block drop serviced sources by itself once the line has fired (auto-clear).

Register map:

| Address | Register | Access |
|---|---|---|
| 0 | Group status | read-only |
| 1 | Group enable | read/write |
| 2 | Control | read/write |
| 8+g | Source status of group g | see R7, R8 |
| 16+g | Source enable of group g | read/write |

Unmapped addresses read as 0.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all enables are 0, control is 0, every status bit is 0 and `irq_n` is 1.
- R2: A one-cycle event pulse sets its sticky source bit, which stays set until cleared. If a set and a clear hit the same bit in the same cycle, the bit ends set.
- R3: Bit g of the group status register (address 0) is the OR over group g of sticky bit AND source enable. Group bits, MSB to LSB, are: SA6 event, loopback code, receive clock loss, one-second tick, HDLC, slip buffer, alarm/error, frame.
- R4: `irq_n` is a register. It goes low one cycle after the master enable is 1 and (group status AND group enable) is non-zero, and it is high otherwise.
- R5: A group whose group-enable bit is 0 never pulls `irq_n` low.
- R6: With the master enable (control bit 0) at 0, `irq_n` stays high.
- R7: With control bit 1 = 0 (read-clear), a read of a source status register clears exactly the bits it returned as 1. Reads of other registers clear nothing.
- R8: With control bit 1 = 1 (write-one-clear), reads have no side effect. A write to a source status register clears the bits written as 1 and leaves the others.
- R9: With control bit 2 = 1 (auto-clear), every contributing sticky bit clears in the cycle after `irq_n` has gone low.
- R10: Read data appears on `rdata` one cycle after the read strobe. Unmapped addresses read as 0. Control reads back only bits 2:0.
- R11: Writes to the group status register, and writes to source status registers in read-clear mode, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 8*NSRC | One-cycle event pulses, group g at bits g*NSRC +: NSRC |
| addr | input | ADDR_W | Register address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after `rd` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with `NSRC` = 4 and `ADDR_W` = 5. With these values all 32 source bits fit into short random runs, and each group's source register fills the low nibble of the bus. Random control writes flip the design between read-clear, write-one-clear and auto-clear while events keep arriving. This reaches cases that directed tests would rarely hit: a clear racing a new event, and auto-clear removing one group while another group stays pending.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC   = 4,
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8*NSRC-1:0]    evt,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 irq_n
);
  localparam int NGRP    = 8;
  localparam int NBIT    = NGRP * NSRC;
  localparam int ST_BASE = 8;
  localparam int EN_BASE = 16;

  logic [NBIT-1:0] sticky, src_en, clr;
  logic [NGRP-1:0] grp_stat, grp_en;
  logic [2:0]      ctrl;
  logic            irq_q;
  logic [7:0]      rd_mux;

  wire master  = ctrl[0];
  wire w1c     = ctrl[1];
  wire autoclr = ctrl[2];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_stat[g] = |(sticky[g*NSRC +: NSRC] & src_en[g*NSRC +: NSRC]);
  end

  always_comb begin
    clr    = '0;
    rd_mux = '0;
    if (int'(addr) == 0) rd_mux = grp_stat;
    if (int'(addr) == 1) rd_mux = grp_en;
    if (int'(addr) == 2) rd_mux = {5'b0, ctrl};
    for (int g = 0; g < NGRP; g++) begin
      if (int'(addr) == ST_BASE + g) begin
        rd_mux[NSRC-1:0] = sticky[g*NSRC +: NSRC];
        if (rd && !w1c) clr[g*NSRC +: NSRC] = sticky[g*NSRC +: NSRC];
        if (wr && w1c)  clr[g*NSRC +: NSRC] = clr[g*NSRC +: NSRC] | wdata[NSRC-1:0];
      end
      if (int'(addr) == EN_BASE + g) rd_mux[NSRC-1:0] = src_en[g*NSRC +: NSRC];
      if (autoclr && irq_q)
        clr[g*NSRC +: NSRC] = clr[g*NSRC +: NSRC] |
          (sticky[g*NSRC +: NSRC] & src_en[g*NSRC +: NSRC] & {NSRC{grp_en[g]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      src_en <= '0;
      grp_en <= '0;
      ctrl   <= '0;
      irq_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      sticky <= (sticky & ~clr) | evt;
      irq_q  <= master && |(grp_stat & grp_en);
      if (rd) rdata <= rd_mux;
      if (wr) begin
        if (int'(addr) == 1) grp_en <= wdata;
        if (int'(addr) == 2) ctrl   <= wdata[2:0];
        for (int g = 0; g < NGRP; g++)
          if (int'(addr) == EN_BASE + g) src_en[g*NSRC +: NSRC] <= wdata[NSRC-1:0];
      end
    end
  end

  assign irq_n = ~irq_q;

  // R2
  evt_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |evt |=> ((sticky & $past(evt)) == $past(evt)));
  // R4
  irq_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && |(grp_stat & grp_en)) |=> !irq_n);
  // R5
  grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_stat & grp_en) == '0) |=> irq_n);
  // R6
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> irq_n);
  // R8
  w1c_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !autoclr && !wr) |=> (($past(sticky) & ~sticky) == '0));
  // R1
  always_comb if (!rst_n) reset_state_chk: assert (sticky == '0);
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NS = 4;
  localparam int NB = 8 * NS;

  logic clk = 0, rst_n = 0;
  logic [NB-1:0] evt = '0;
  logic [4:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_n;

  irq_aggregator #(.NSRC(NS), .ADDR_W(5)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";
  logic [NB-1:0] m_st = '0, m_sen = '0;
  logic [7:0] m_gen = '0, m_rd = '0;
  logic [2:0] m_ctl = '0;
  logic m_irq = 0;
  logic done = 0;

  function automatic logic [7:0] gstat(logic [NB-1:0] st, logic [NB-1:0] se);
    logic [7:0] r;
    for (int g = 0; g < 8; g++) r[g] = |(st[g*NS +: NS] & se[g*NS +: NS]);
    return r;
  endfunction

  function automatic logic [7:0] readval(int a);
    if (a == 0) return gstat(m_st, m_sen);
    if (a == 1) return m_gen;
    if (a == 2) return {5'b0, m_ctl};
    if (a >= 8 && a < 16) return {4'b0, m_st[(a-8)*NS +: NS]};
    if (a >= 16 && a < 24) return {4'b0, m_sen[(a-16)*NS +: NS]};
    return 8'h00;
  endfunction

  task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // op: 0 idle, 1 read, 2 write
  task automatic step(logic [NB-1:0] e, int op, int a, logic [7:0] d);
    logic [NB-1:0] clrv, n_st, n_sen;
    logic [7:0] n_gen, n_rd;
    logic [2:0] n_ctl;
    logic n_irq;
    @(negedge clk);
    evt = e; rd = (op == 1); wr = (op == 2); addr = 5'(a); wdata = d;
    clrv = '0;
    if (a >= 8 && a < 16) begin
      if (op == 1 && !m_ctl[1]) clrv[(a-8)*NS +: NS] = m_st[(a-8)*NS +: NS];
      if (op == 2 && m_ctl[1])  clrv[(a-8)*NS +: NS] = d[NS-1:0];
    end
    if (m_ctl[2] && m_irq)
      for (int g = 0; g < 8; g++)
        clrv[g*NS +: NS] |= m_st[g*NS +: NS] & m_sen[g*NS +: NS] & {NS{m_gen[g]}};
    n_st = (m_st & ~clrv) | e;
    n_irq = m_ctl[0] && |(gstat(m_st, m_sen) & m_gen);
    n_rd = (op == 1) ? readval(a) : m_rd;
    n_gen = m_gen; n_ctl = m_ctl; n_sen = m_sen;
    if (op == 2) begin
      if (a == 1) n_gen = d;
      if (a == 2) n_ctl = d[2:0];
      if (a >= 16 && a < 24) n_sen[(a-16)*NS +: NS] = d[NS-1:0];
    end
    @(posedge clk); #1;
    m_st = n_st; m_irq = n_irq; m_rd = n_rd; m_gen = n_gen; m_ctl = n_ctl; m_sen = n_sen;
    evt = '0; rd = 0; wr = 0;
    chk({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, ~m_irq});
    if (op == 1) chk({tag, " rdata"}, rdata, m_rd);
  endtask

  function automatic logic [NB-1:0] ev(int g, int s);
    logic [NB-1:0] r = '0;
    r[g*NS + s] = 1'b1;
    return r;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    step('0, 1, 0, 0); step('0, 1, 1, 0); step('0, 1, 2, 0); step('0, 1, 11, 0);

    tag = "R10";
    for (int g = 0; g < 8; g++) step('0, 2, 16 + g, 8'hFF);
    step('0, 2, 1, 8'hFF);
    step('0, 2, 2, 8'hF9);
    step('0, 1, 2, 0); step('0, 1, 5, 0); step('0, 1, 19, 0);

    tag = "R2";
    step(ev(3, 1), 0, 0, 0);
    step('0, 0, 0, 0); step('0, 0, 0, 0);
    tag = "R3"; step('0, 1, 0, 0);
    tag = "R7"; step('0, 1, 0, 0); step('0, 1, 11, 0); step('0, 1, 11, 0);
    tag = "R2";
    step(ev(5, 2), 0, 0, 0);
    step(ev(5, 2), 1, 13, 0);
    step('0, 1, 13, 0);
    step('0, 1, 13, 0);

    tag = "R11";
    step(ev(0, 0), 0, 0, 0);
    step('0, 2, 0, 8'h00); step('0, 2, 8, 8'hFF);
    step('0, 1, 8, 0); step('0, 1, 0, 0);
    step('0, 1, 8, 0);

    tag = "R5";
    step('0, 2, 1, 8'hF7);
    step(ev(3, 0), 0, 0, 0);
    repeat (3) step('0, 0, 0, 0);
    step('0, 1, 11, 0);
    step('0, 2, 1, 8'hFF);

    tag = "R6";
    step('0, 2, 2, 8'h00);
    step(ev(7, 3), 0, 0, 0);
    repeat (3) step('0, 0, 0, 0);
    step('0, 1, 15, 0);

    tag = "R8";
    step('0, 2, 2, 8'h03);
    step(ev(2, 0) | ev(2, 3), 0, 0, 0);
    step('0, 1, 10, 0); step('0, 1, 10, 0);
    step('0, 2, 10, 8'h01);
    step('0, 1, 10, 0);
    step('0, 2, 10, 8'h08);
    step('0, 1, 10, 0); step('0, 0, 0, 0);

    tag = "R9";
    step('0, 2, 2, 8'h07);
    step(ev(6, 1), 0, 0, 0);
    repeat (4) step('0, 0, 0, 0);
    step('0, 1, 14, 0);

    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      logic [NB-1:0] e;
      int op, a;
      e = '0;
      for (int b = 0; b < NB; b++) if ($urandom % 24 == 0) e[b] = 1'b1;
      op = $urandom % 3;
      a = $urandom % 26;
      if (op == 2 && a == 2 && ($urandom % 4) != 0) a = 8 + $urandom % 8;
      step(e, op, a, 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule